// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds a small set of virtual-to-physical page mappings and looks them up in one step. Every slot can hold any mapping. A slot is tagged with the address-space identifier of the process that owns it, so mappings from several processes can be present together. A slot marked global matches in every address space. Pages are the same size on both sides, so the low offset bits of the virtual address pass through to the physical address unchanged.

A lookup compares the virtual page number and the current address-space identifier against all slots at once. In the same cycle it checks the slot's permission bits against the access type. The result is registered and appears one cycle after the lookup is accepted, as exactly one of hit, miss or fault. After a miss the block raises a refill request and names the missing page. It waits until a refill arrives or an invalidate cancels the request. A refill goes into a free slot when there is one. When every slot is in use, a free-running linear feedback shift register picks the slot to replace. Software or the walker can clear every slot at once, or only the non-global slots of one address space.

A small controller sequences the work through three states. `XS_IDLE` accepts a lookup and moves to `XS_RESP`. `XS_RESP` presents the registered result for one cycle. From there it returns to `XS_IDLE` after a hit or fault, and goes to `XS_MISS_WAIT` after a miss. `XS_MISS_WAIT` holds the refill request. It returns to `XS_IDLE` on a refill write or on either invalidate.

Top module: `asid_xlate_tlb`

## Requirements
- R1: After reset no slot is valid, `lk_ready` is 1, and `rf_req`, `rsp_hit`, `rsp_miss` and `rsp_fault` are 0. The first lookup misses.
- R2: A lookup accepted with `lk_valid` and `lk_ready` both high, whose page number `lk_va[31:12]` and identifier match a valid slot, gives `rsp_hit` in the next cycle. In that cycle `rsp_pa` equals the slot's frame number in bits [31:12] and `lk_va[11:0]` in bits [11:0].
- R3: A slot matches only a lookup with the same identifier, unless its global flag was set at refill. A global slot matches any identifier.
- R4: Permission bit 0 allows loads (`lk_store`=0) and bit 1 allows stores (`lk_store`=1). A matching slot whose permission is missing gives `rsp_fault` with `rsp_pa` zero. Exactly one of hit, miss and fault is reported per accepted lookup, and `rsp_pa` is zero whenever `rsp_hit` is low.
- R5: A lookup that matches nothing gives `rsp_miss`. From the next cycle, `rf_req` is high, `lk_ready` is low, and `rf_req_vpn` and `rf_req_asid` name the missing page. Lookups offered in that time are ignored. The request ends on a refill write or on any invalidate.
- R6: A refill goes into a slot that is not valid whenever one exists, so 16 distinct refills into an empty block all remain present.
- R7: When every slot is valid, a refill replaces exactly one slot, chosen by the pseudo-random register. All other mappings are kept.
- R8: `inv_all` clears every slot, including global ones, in one cycle.
- R9: `inv_asid_en` clears, in one cycle, every non-global slot whose identifier equals `inv_asid`. Global slots and slots of other identifiers are kept.
- R10: A refill written in the same cycle as an invalidate survives that invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup offered |
| lk_va | input | 32 | Virtual address: page number [31:12], offset [11:0] |
| lk_asid | input | 8 | Current address-space identifier |
| lk_store | input | 1 | Access type: 1 store, 0 load |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No matching slot |
| rsp_fault | output | 1 | Matching slot forbids the access |
| rsp_pa | output | 32 | Physical address on a hit, else zero |
| rf_req | output | 1 | Refill requested |
| rf_req_vpn | output | 20 | Page number that missed |
| rf_req_asid | output | 8 | Identifier that missed |
| rf_valid | input | 1 | Write a refill this cycle |
| rf_vpn | input | 20 | Refill page number |
| rf_asid | input | 8 | Refill identifier |
| rf_pfn | input | 20 | Refill frame number |
| rf_perm | input | 2 | Refill permissions: bit 0 load, bit 1 store |
| rf_global | input | 1 | Refill slot matches all identifiers |
| inv_all | input | 1 | Clear every slot |
| inv_asid_en | input | 1 | Clear non-global slots of `inv_asid` |
| inv_asid | input | 8 | Identifier to clear |

## Verification
The checker watches every cycle for properties of the result and the handshake. It checks that hit, miss and fault are never raised together. It checks that every accepted lookup gives exactly one result in the next cycle, and that no result appears without an accepted lookup. It checks that the physical address is zero when there is no hit. It also checks that a miss is followed by a refill request, which stays up until a refill or invalidate ends it and never overlaps lookup readiness. Properties of the stored contents need the bench's scenarios. These are identifier isolation and the global override, permission faults, free-slot preference, single-slot random eviction when full, the reach of both invalidates, and a refill surviving a same-cycle invalidate.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    typedef enum logic [1:0] {
        XS_IDLE      = 2'd0,
        XS_RESP      = 2'd1,
        XS_MISS_WAIT = 2'd2
    } xlt_state_e;

    localparam int XLT_PERM_W  = 2;
    localparam int XLT_PERM_LD = 0;
    localparam int XLT_PERM_ST = 1;

    localparam int XLT_DEF_SLOTS  = 16;
    localparam int XLT_DEF_VPN_W  = 20;
    localparam int XLT_DEF_PFN_W  = 20;
    localparam int XLT_DEF_ASID_W = 8;
    localparam int XLT_DEF_OFF_W  = 12;
    localparam int XLT_DEF_RND_W  = 16;

endpackage

// File: rtl/xlt_entry_array.sv
module xlt_entry_array #(
    parameter int SLOTS  = 16,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PERM_W = 2,
    parameter int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  cmp_vpn,
    input  logic [ASID_W-1:0] cmp_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              wr_glb,
    input  logic              clr_all,
    input  logic              clr_asid_en,
    input  logic [ASID_W-1:0] clr_asid,
    output logic              match_any,
    output logic [PFN_W-1:0]  sel_pfn,
    output logic [PERM_W-1:0] sel_perm,
    output logic [SLOTS-1:0]  valid_vec
);

    logic [SLOTS-1:0]  slot_v;
    logic [SLOTS-1:0]  slot_g;
    logic [VPN_W-1:0]  slot_vpn  [SLOTS];
    logic [ASID_W-1:0] slot_asid [SLOTS];
    logic [PFN_W-1:0]  slot_pfn  [SLOTS];
    logic [PERM_W-1:0] slot_perm [SLOTS];
    logic [SLOTS-1:0]  match_vec;

    // valid and global flags: the refill write wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_v <= '0;
            slot_g <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    slot_v[i] <= 1'b1;
                    slot_g[i] <= wr_glb;
                end else if (clr_all) begin
                    slot_v[i] <= 1'b0;
                end else if (clr_asid_en && !slot_g[i] && (slot_asid[i] == clr_asid)) begin
                    slot_v[i] <= 1'b0;
                end
            end
        end
    end

    // payload storage needs no reset: it is only read behind a valid flag
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_vpn[wr_idx]  <= wr_vpn;
            slot_asid[wr_idx] <= wr_asid;
            slot_pfn[wr_idx]  <= wr_pfn;
            slot_perm[wr_idx] <= wr_perm;
        end
    end

    // one comparator per slot
    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_cmp
        assign match_vec[gi] = slot_v[gi]
                             && (slot_vpn[gi] == cmp_vpn)
                             && (slot_g[gi] || (slot_asid[gi] == cmp_asid));
    end

    // lowest matching slot drives the selected fields
    always_comb begin
        sel_pfn  = '0;
        sel_perm = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                sel_pfn  = slot_pfn[i];
                sel_perm = slot_perm[i];
            end
        end
    end

    assign match_any = |match_vec;
    assign valid_vec = slot_v;

endmodule

// File: rtl/xlt_victim_sel.sv
module xlt_victim_sel #(
    parameter int          SLOTS = 16,
    parameter int          RND_W = 16,
    parameter logic [RND_W-1:0] RND_TAPS = 16'hB400,
    parameter logic [RND_W-1:0] RND_SEED = 16'hACE1,
    parameter int          IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] valid_vec,
    output logic [IDX_W-1:0] victim_idx
);

    localparam bit SLOTS_POW2 = (SLOTS == (1 << IDX_W));

    logic [RND_W-1:0] rnd_q;
    logic [IDX_W-1:0] free_idx;
    logic             have_free;
    logic [IDX_W-1:0] rnd_idx;

    // free-running Galois shift register, never zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q <= RND_SEED;
        end else if (rnd_q[0]) begin
            rnd_q <= (rnd_q >> 1) ^ RND_TAPS;
        end else begin
            rnd_q <= rnd_q >> 1;
        end
    end

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    if (SLOTS_POW2) begin : g_rnd_slice
        assign rnd_idx = rnd_q[IDX_W-1:0];
    end else begin : g_rnd_mod
        assign rnd_idx = IDX_W'(rnd_q % RND_W'(SLOTS));
    end

    assign victim_idx = have_free ? free_idx : rnd_idx;

endmodule

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
    import xlt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lk_valid,
    input  logic match_any,
    input  logic perm_ok,
    input  logic rf_valid,
    input  logic inv_any,
    output logic accept,
    output logic lk_ready,
    output logic rf_req,
    output logic rsp_hit,
    output logic rsp_miss,
    output logic rsp_fault
);

    xlt_state_e state_q, state_d;

    assign accept = (state_q == XS_IDLE) && lk_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:      if (lk_valid) state_d = XS_RESP;
            XS_RESP:      state_d = rsp_miss ? XS_MISS_WAIT : XS_IDLE;
            XS_MISS_WAIT: if (rf_valid || inv_any) state_d = XS_IDLE;
            default:      state_d = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // registered result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_hit   <= accept &&  match_any &&  perm_ok;
            rsp_fault <= accept &&  match_any && !perm_ok;
            rsp_miss  <= accept && !match_any;
        end
    end

    assign lk_ready = (state_q == XS_IDLE);
    assign rf_req   = (state_q == XS_MISS_WAIT);

endmodule

// File: rtl/asid_xlate_tlb.sv
module asid_xlate_tlb
    import xlt_pkg::*;
#(
    parameter int SLOTS  = XLT_DEF_SLOTS,
    parameter int VPN_W  = XLT_DEF_VPN_W,
    parameter int PFN_W  = XLT_DEF_PFN_W,
    parameter int ASID_W = XLT_DEF_ASID_W,
    parameter int OFF_W  = XLT_DEF_OFF_W,
    parameter int RND_W  = XLT_DEF_RND_W,
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PFN_W + OFF_W,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_valid,
    input  logic [VA_W-1:0]       lk_va,
    input  logic [ASID_W-1:0]     lk_asid,
    input  logic                  lk_store,
    output logic                  lk_ready,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic                  rsp_fault,
    output logic [PA_W-1:0]       rsp_pa,
    output logic                  rf_req,
    output logic [VPN_W-1:0]      rf_req_vpn,
    output logic [ASID_W-1:0]     rf_req_asid,
    input  logic                  rf_valid,
    input  logic [VPN_W-1:0]      rf_vpn,
    input  logic [ASID_W-1:0]     rf_asid,
    input  logic [PFN_W-1:0]      rf_pfn,
    input  logic [XLT_PERM_W-1:0] rf_perm,
    input  logic                  rf_global,
    input  logic                  inv_all,
    input  logic                  inv_asid_en,
    input  logic [ASID_W-1:0]     inv_asid
);

    logic                  match_any;
    logic [PFN_W-1:0]      sel_pfn;
    logic [XLT_PERM_W-1:0] sel_perm;
    logic [SLOTS-1:0]      valid_vec;
    logic [IDX_W-1:0]      victim_idx;
    logic                  accept;
    logic                  perm_ok;
    logic [VPN_W-1:0]      lk_vpn;
    logic [OFF_W-1:0]      lk_off;

    assign lk_vpn  = lk_va[VA_W-1:OFF_W];
    assign lk_off  = lk_va[OFF_W-1:0];
    assign perm_ok = lk_store ? sel_perm[XLT_PERM_ST] : sel_perm[XLT_PERM_LD];

    xlt_entry_array #(
        .SLOTS (SLOTS),
        .VPN_W (VPN_W),
        .PFN_W (PFN_W),
        .ASID_W(ASID_W),
        .PERM_W(XLT_PERM_W),
        .IDX_W (IDX_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_vpn    (lk_vpn),
        .cmp_asid   (lk_asid),
        .wr_en      (rf_valid),
        .wr_idx     (victim_idx),
        .wr_vpn     (rf_vpn),
        .wr_asid    (rf_asid),
        .wr_pfn     (rf_pfn),
        .wr_perm    (rf_perm),
        .wr_glb     (rf_global),
        .clr_all    (inv_all),
        .clr_asid_en(inv_asid_en),
        .clr_asid   (inv_asid),
        .match_any  (match_any),
        .sel_pfn    (sel_pfn),
        .sel_perm   (sel_perm),
        .valid_vec  (valid_vec)
    );

    xlt_victim_sel #(
        .SLOTS(SLOTS),
        .RND_W(RND_W),
        .IDX_W(IDX_W)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .victim_idx(victim_idx)
    );

    xlt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_valid (lk_valid),
        .match_any(match_any),
        .perm_ok  (perm_ok),
        .rf_valid (rf_valid),
        .inv_any  (inv_all || inv_asid_en),
        .accept   (accept),
        .lk_ready (lk_ready),
        .rf_req   (rf_req),
        .rsp_hit  (rsp_hit),
        .rsp_miss (rsp_miss),
        .rsp_fault(rsp_fault)
    );

    // physical address is driven only in the hit cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_pa <= '0;
        end else if (accept && match_any && perm_ok) begin
            rsp_pa <= {sel_pfn, lk_off};
        end else begin
            rsp_pa <= '0;
        end
    end

    // miss context for the walker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_req_vpn  <= '0;
            rf_req_asid <= '0;
        end else if (accept) begin
            rf_req_vpn  <= lk_vpn;
            rf_req_asid <= lk_asid;
        end
    end

endmodule

// File: rtl/asid_xlate_tlb_chk.sv
module asid_xlate_tlb_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic            lk_ready,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rf_req,
    input logic            rf_valid,
    input logic            inv_all,
    input logic            inv_asid_en
);

    assert_one_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss, rsp_fault}));

    assert_pa_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_pa == '0));

    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> (rsp_hit || rsp_miss || rsp_fault));

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready) |=> !(rsp_hit || rsp_miss || rsp_fault));

    assert_miss_requests_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |=> rf_req);

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_valid && !inv_all && !inv_asid_en) |=> rf_req);

    assert_req_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_valid) |=> (!rf_req && lk_ready));

    assert_req_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_req && lk_ready));

endmodule

bind asid_xlate_tlb asid_xlate_tlb_chk #(.PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_ready   (lk_ready),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_fault  (rsp_fault),
    .rsp_pa     (rsp_pa),
    .rf_req     (rf_req),
    .rf_valid   (rf_valid),
    .inv_all    (inv_all),
    .inv_asid_en(inv_asid_en)
);

// File: tb/test_asid_xlate_tlb.sv
`timescale 1ns/1ps
module test_asid_xlate_tlb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_store = 1'b0;
    logic        lk_ready;
    logic        rsp_hit, rsp_miss, rsp_fault;
    logic [31:0] rsp_pa;
    logic        rf_req;
    logic [19:0] rf_req_vpn;
    logic [7:0]  rf_req_asid;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [7:0]  rf_asid = '0;
    logic [19:0] rf_pfn = '0;
    logic [1:0]  rf_perm = '0;
    logic        rf_global = 1'b0;
    logic        inv_all = 1'b0;
    logic        inv_asid_en = 1'b0;
    logic [7:0]  inv_asid = '0;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    asid_xlate_tlb i_asid_xlate_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_store(lk_store),
        .lk_ready(lk_ready),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .rf_req(rf_req), .rf_req_vpn(rf_req_vpn), .rf_req_asid(rf_req_asid),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_pfn(rf_pfn),
        .rf_perm(rf_perm), .rf_global(rf_global),
        .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // result flags packed as {fault, miss, hit}
    task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic st,
                          output logic [2:0] res, output logic [31:0] pa);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_store = st;
        @(posedge clk); #1;
        res = {rsp_fault, rsp_miss, rsp_hit};
        pa  = rsp_pa;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] pfn,
                          input logic [1:0] perm, input logic glb);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = vpn; rf_asid = asid; rf_pfn = pfn; rf_perm = perm; rf_global = glb;
        @(posedge clk); #1;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic kill_asid(input logic [7:0] asid);
        @(negedge clk);
        inv_asid_en = 1'b1; inv_asid = asid;
        @(posedge clk); #1;
        @(negedge clk);
        inv_asid_en = 1'b0;
    endtask

    task automatic kill_all();
        @(negedge clk);
        inv_all = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    // expect a miss, then release the request with an invalidate of an unused identifier
    task automatic expect_miss(input logic [31:0] va, input logic [7:0] asid, input string tag);
        logic [2:0] r; logic [31:0] pa;
        lookup(va, asid, 1'b0, r, pa);
        chk(r == 3'b010, tag, {29'd0, r}, 32'h2);
        kill_asid(8'hEE);
    endtask

    task automatic expect_hit(input logic [31:0] va, input logic [7:0] asid, input logic st,
                              input logic [31:0] exp_pa, input string tag);
        logic [2:0] r; logic [31:0] pa;
        lookup(va, asid, st, r, pa);
        chk(r == 3'b001 && pa == exp_pa, tag, pa, exp_pa);
        if (r == 3'b010) kill_asid(8'hEE);
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        chk(lk_ready == 1'b1 && rf_req == 1'b0, "R1 ready/req after reset", {30'd0, lk_ready, rf_req}, 32'h2);
        chk({rsp_hit, rsp_miss, rsp_fault} == 3'b000, "R1 flags after reset",
            {29'd0, rsp_hit, rsp_miss, rsp_fault}, 32'h0);
        expect_miss(32'h1234_5000, 8'd1, "R1 empty lookup misses");
    endtask

    task automatic t_hit_r2();
        refill(20'h12345, 8'd1, 20'hABCDE, 2'b11, 1'b0);
        expect_hit(32'h1234_5678, 8'd1, 1'b0, 32'hABCD_E678, "R2 load hit address");
        expect_hit(32'h1234_5FFF, 8'd1, 1'b1, 32'hABCD_EFFF, "R2 store hit address");
    endtask

    task automatic t_miss_r5();
        logic [2:0] r; logic [31:0] pa;
        lookup(32'h5555_5ABC, 8'd1, 1'b0, r, pa);
        chk(r == 3'b010, "R5 miss flag", {29'd0, r}, 32'h2);
        @(posedge clk); #1;
        chk(rf_req == 1'b1 && lk_ready == 1'b0, "R5 request raised", {30'd0, rf_req, lk_ready}, 32'h2);
        chk(rf_req_vpn == 20'h55555 && rf_req_asid == 8'd1, "R5 request names page",
            {4'd0, rf_req_asid, rf_req_vpn}, {4'd0, 8'd1, 20'h55555});
        @(negedge clk);
        lk_valid = 1'b1; lk_va = 32'h1234_5000; lk_asid = 8'd1; lk_store = 1'b0;
        @(posedge clk); #1;
        chk({rsp_hit, rsp_miss, rsp_fault} == 3'b000 && rf_req == 1'b1, "R5 lookup ignored while waiting",
            {28'd0, rsp_hit, rsp_miss, rsp_fault, rf_req}, 32'h1);
        @(negedge clk);
        lk_valid = 1'b0;
        refill(20'h55555, 8'd1, 20'h00777, 2'b11, 1'b0);
        chk(rf_req == 1'b0 && lk_ready == 1'b1, "R5 refill ends request", {30'd0, rf_req, lk_ready}, 32'h1);
        expect_hit(32'h5555_5ABC, 8'd1, 1'b0, 32'h0077_7ABC, "R5 refilled page hits");
    endtask

    task automatic t_perm_r4();
        logic [2:0] r; logic [31:0] pa;
        refill(20'h60000, 8'd1, 20'h0A000, 2'b01, 1'b0);
        refill(20'h60001, 8'd1, 20'h0A001, 2'b10, 1'b0);
        expect_hit(32'h6000_0010, 8'd1, 1'b0, 32'h0A00_0010, "R4 read-only load");
        lookup(32'h6000_0010, 8'd1, 1'b1, r, pa);
        chk(r == 3'b100 && pa == 32'h0, "R4 read-only store faults", {r, pa[28:0]}, {3'b100, 29'd0});
        lookup(32'h6000_1020, 8'd1, 1'b0, r, pa);
        chk(r == 3'b100 && pa == 32'h0, "R4 write-only load faults", {r, pa[28:0]}, {3'b100, 29'd0});
        expect_hit(32'h6000_1020, 8'd1, 1'b1, 32'h0A00_1020, "R4 write-only store");
    endtask

    task automatic t_asid_r3();
        refill(20'h70000, 8'd2, 20'h0B000, 2'b11, 1'b0);
        expect_miss(32'h7000_0000, 8'd3, "R3 other identifier misses");
        expect_hit(32'h7000_0004, 8'd2, 1'b0, 32'h0B00_0004, "R3 own identifier hits");
        refill(20'h70001, 8'd2, 20'h0B001, 2'b11, 1'b1);
        expect_hit(32'h7000_1008, 8'd9, 1'b0, 32'h0B00_1008, "R3 global matches any identifier");
    endtask

    task automatic t_inv_asid_r9();
        kill_asid(8'd2);
        expect_miss(32'h7000_0000, 8'd2, "R9 non-global slot cleared");
        expect_hit(32'h7000_1000, 8'd2, 1'b0, 32'h0B00_1000, "R9 global slot kept");
        expect_hit(32'h1234_5000, 8'd1, 1'b0, 32'hABCD_E000, "R9 other identifier kept");
    endtask

    task automatic t_inv_all_r8();
        kill_all();
        expect_miss(32'h1234_5000, 8'd1, "R8 ordinary slot cleared");
        expect_miss(32'h7000_1000, 8'd9, "R8 global slot cleared");
    endtask

    task automatic t_fill_r6();
        int hits = 0;
        for (int i = 0; i < 16; i++) refill(20'h00100 + 20'(i), 8'd4, 20'h00800 + 20'(i), 2'b11, 1'b0);
        for (int i = 0; i < 16; i++) begin
            logic [2:0] r; logic [31:0] pa;
            lookup({20'h00100 + 20'(i), 12'h0}, 8'd4, 1'b0, r, pa);
            if (r == 3'b001 && pa == {20'h00800 + 20'(i), 12'h0}) hits++;
            if (r == 3'b010) kill_asid(8'hEE);
        end
        chk(hits == 16, "R6 all sixteen refills present", hits, 16);
    endtask

    task automatic t_evict_r7();
        int hits = 0;
        refill(20'h001FF, 8'd4, 20'h008FF, 2'b11, 1'b0);
        expect_hit(32'h001F_F000, 8'd4, 1'b0, 32'h008F_F000, "R7 new mapping present");
        for (int i = 0; i < 16; i++) begin
            logic [2:0] r; logic [31:0] pa;
            lookup({20'h00100 + 20'(i), 12'h0}, 8'd4, 1'b0, r, pa);
            if (r == 3'b001) hits++;
            if (r == 3'b010) kill_asid(8'hEE);
        end
        chk(hits == 15, "R7 exactly one slot displaced", hits, 15);
    endtask

    task automatic t_same_cycle_r10();
        @(negedge clk);
        inv_all = 1'b1;
        rf_valid = 1'b1; rf_vpn = 20'h09ABC; rf_asid = 8'd5; rf_pfn = 20'h0C000; rf_perm = 2'b11; rf_global = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        inv_all = 1'b0; rf_valid = 1'b0;
        expect_hit(32'h09AB_C100, 8'd5, 1'b0, 32'h0C00_0100, "R10 refill survives clear-all");
        expect_miss(32'h0010_0000, 8'd4, "R10 older slots cleared");
        @(negedge clk);
        inv_asid_en = 1'b1; inv_asid = 8'd5;
        rf_valid = 1'b1; rf_vpn = 20'h09ABD; rf_asid = 8'd5; rf_pfn = 20'h0C001; rf_perm = 2'b11; rf_global = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        inv_asid_en = 1'b0; rf_valid = 1'b0;
        expect_hit(32'h09AB_D200, 8'd5, 1'b0, 32'h0C00_1200, "R10 refill survives identifier clear");
        expect_miss(32'h09AB_C000, 8'd5, "R10 same identifier slot cleared");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_hit_r2();
        t_miss_r5();
        t_perm_r4();
        t_asid_r3();
        t_inv_asid_r9();
        t_inv_all_r8();
        t_fill_r6();
        t_evict_r7();
        t_same_cycle_r10();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule